// File: doc/BRIEF.md
# K2 Line Defect and Mode Mismatch Detector

This block watches the low nibble of the received K2 overhead byte once per frame. It declares and clears three line-level defects: line alarm indication (AIS), line remote defect indication (RDI) and protection mode mismatch. No defect follows a single frame. Each one is filtered by a persistence count of 3 frames (SDH) or 5 frames (SONET), and that count applies both when a defect is entered and when it is left.

Provisioning inputs select the persistence count, the expected protection architecture (1+1 or 1:n) and the expected switching direction (bidirectional or unidirectional). Every change of a defect state, whether it is declared or removed, sets a sticky status bit. A single interrupt line is raised for any status bit whose mask is clear. Software clears the status bits either by reading them or by writing ones to them, as chosen by a clear-mode input.

Top module: `k2_defect_mon`

## Requirements
- R1: Line AIS (`ais_state`) is declared on the strobe of the N-th consecutive strobed frame whose `k2_lsn[2:0]` equals 3'b111. N is the persistence count.
- R2: Line AIS is removed on the strobe of the N-th consecutive strobed frame whose `k2_lsn[2:0]` is anything other than 3'b111.
- R3: Line RDI (`rdi_state`) is declared after N consecutive strobed frames with `k2_lsn[2:0]` equal to 3'b110. It is removed after N consecutive frames with any other value.
- R4: N is 3 when `pers_sel` is 1 and 5 when `pers_sel` is 0.
- R5: A frame is a mismatch frame when `k2_lsn[3]` differs from `arch_sel` (0 means 1+1, 1 means 1:n).
- R6: A frame is also a mismatch frame when `dir_sel` is 0 (bidirectional) and `k2_lsn[2:0]` is 3'b100, or when `dir_sel` is 1 (unidirectional) and `k2_lsn[2:0]` is 3'b101.
- R7: `mism_state` is declared after N consecutive mismatch frames. It is removed after N consecutive frames with no mismatch.
- R8: Any strobed frame that agrees with a defect's current state restarts that defect's count. An interrupted run therefore never changes the state.
- R9: Clock cycles without `frame_stb` neither count nor change any defect state, whatever `k2_lsn` holds.
- R10: `status` bit 0 (AIS), bit 1 (RDI) and bit 2 (mismatch) are set on the edge where the matching state changes in either direction. Each bit stays set until it is cleared.
- R11: When `clr_mode` is 0, a cycle with `stat_wr` clears each status bit whose `stat_wdata` bit is 1. `stat_rd` has no effect in this mode.
- R12: When `clr_mode` is 1, a cycle with `stat_rd` clears all status bits. `stat_wr` has no effect in this mode. In both modes a new state change in the same cycle wins over the clear.
- R13: `irq` is high exactly when some status bit is set and its `irq_mask` bit is 0.
- R14: After reset all three defect states, all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking a new K2 value |
| k2_lsn | input | 4 | Low nibble of the received K2 byte |
| pers_sel | input | 1 | Persistence select: 1 = 3 frames, 0 = 5 frames |
| arch_sel | input | 1 | Provisioned architecture: 0 = 1+1, 1 = 1:n |
| dir_sel | input | 1 | Provisioned direction: 0 = bidirectional, 1 = unidirectional |
| irq_mask | input | 3 | Interrupt masks, same bit order as status |
| clr_mode | input | 1 | 0 = clear on write, 1 = clear on read |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Write-one-to-clear data |
| ais_state | output | 1 | Line AIS defect state |
| rdi_state | output | 1 | Line RDI defect state |
| mism_state | output | 1 | Mode mismatch defect state |
| status | output | 3 | Sticky change-of-state bits {mismatch, RDI, AIS} |
| irq | output | 1 | Combined interrupt |

## Verification
The bench breaks a run one frame short of the 5-frame count and then completes it. A design that failed to restart its counter would declare AIS too early.

It changes `k2_lsn` without a strobe. A design that counted clock cycles instead of frames would change state here.

It moves straight from one mismatch cause to the other: a bit 3 mismatch after a direction mismatch, and in the other order. A design that restarted on the cause rather than on the condition would drop the mismatch.

It exercises clear-on-read and clear-on-write each against the opposite strobe. A design that ignored the mode would lose status bits that must survive.

// File: rtl/k2_mon_pkg.sv
package k2_mon_pkg;
  localparam int NUM_DEF = 3;

  typedef enum int {
    DEF_AIS  = 0,
    DEF_RDI  = 1,
    DEF_MISM = 2
  } def_idx_e;

  localparam logic [2:0] PAT_AIS   = 3'b111;
  localparam logic [2:0] PAT_RDI   = 3'b110;
  localparam logic [2:0] PAT_BIDIR = 3'b101;
  localparam logic [2:0] PAT_UNI   = 3'b100;
endpackage

// File: rtl/k2_classify.sv
module k2_classify
  import k2_mon_pkg::*;
(
  input  logic [3:0]         k2_lsn,
  input  logic               arch_sel,
  input  logic               dir_sel,
  output logic [NUM_DEF-1:0] cond
);
  logic       arch_bad;
  logic       dir_bad;
  logic [2:0] opposite_dir;

  always_comb begin
    // The pattern that indicates the non-provisioned direction
    opposite_dir    = dir_sel ? PAT_BIDIR : PAT_UNI;
    arch_bad        = (k2_lsn[3] != arch_sel);
    dir_bad         = (k2_lsn[2:0] == opposite_dir);
    cond            = '0;
    cond[DEF_AIS]   = (k2_lsn[2:0] == PAT_AIS);
    cond[DEF_RDI]   = (k2_lsn[2:0] == PAT_RDI);
    cond[DEF_MISM]  = arch_bad | dir_bad;
  end
endmodule

// File: rtl/k2_persist_filt.sv
module k2_persist_filt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             state,
  output logic             flip
);
  logic [CNT_W-1:0] run_q, run_d;
  logic             state_d;
  logic [CNT_W-1:0] run_inc;

  always_comb begin
    run_inc = run_q + 1'b1;
    run_d   = run_q;
    state_d = state;
    flip    = 1'b0;
    if (frame_en) begin
      if (cond == state) begin
        run_d = '0;
      end else if (run_inc >= limit) begin
        run_d   = '0;
        state_d = ~state;
        flip    = 1'b1;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      state <= 1'b0;
    end else if (frame_en) begin
      run_q <= run_d;
      state <= state_d;
    end
  end
endmodule

// File: rtl/k2_status_regs.sv
module k2_status_regs #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_evt,
  input  logic          clr_mode,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic [NB-1:0] stat_wdata,
  input  logic [NB-1:0] irq_mask,
  output logic [NB-1:0] status,
  output logic          irq
);
  logic [NB-1:0] clr_vec;
  logic [NB-1:0] status_d;
  logic          upd_en;

  always_comb begin
    if (clr_mode) clr_vec = stat_rd ? {NB{1'b1}} : '0;
    else          clr_vec = stat_wr ? stat_wdata : '0;
    status_d = (status & ~clr_vec) | set_evt;
    upd_en   = (|clr_vec) | (|set_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= '0;
    else if (upd_en) status <= status_d;
  end

  assign irq = |(status & ~irq_mask);
endmodule

// File: rtl/k2_defect_mon.sv
module k2_defect_mon
  import k2_mon_pkg::*;
#(
  parameter int PERS_SHORT = 3,
  parameter int PERS_LONG  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  logic [3:0]         k2_lsn,
  input  logic               pers_sel,
  input  logic               arch_sel,
  input  logic               dir_sel,
  input  logic [NUM_DEF-1:0] irq_mask,
  input  logic               clr_mode,
  input  logic               stat_rd,
  input  logic               stat_wr,
  input  logic [NUM_DEF-1:0] stat_wdata,
  output logic               ais_state,
  output logic               rdi_state,
  output logic               mism_state,
  output logic [NUM_DEF-1:0] status,
  output logic               irq
);
  localparam int CNT_W = $clog2(((PERS_LONG > PERS_SHORT) ? PERS_LONG : PERS_SHORT) + 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(PERS_SHORT);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(PERS_LONG);

  logic [NUM_DEF-1:0] cond;
  logic [NUM_DEF-1:0] def_state;
  logic [NUM_DEF-1:0] def_flip;
  logic [CNT_W-1:0]   limit;

  assign limit = pers_sel ? LIM_SHORT : LIM_LONG;

  k2_classify u_cls (
    .k2_lsn   (k2_lsn),
    .arch_sel (arch_sel),
    .dir_sel  (dir_sel),
    .cond     (cond)
  );

  for (genvar g = 0; g < NUM_DEF; g++) begin : g_filt
    k2_persist_filt #(.CNT_W(CNT_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_en (frame_stb),
      .cond     (cond[g]),
      .limit    (limit),
      .state    (def_state[g]),
      .flip     (def_flip[g])
    );
  end

  k2_status_regs #(.NB(NUM_DEF)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (def_flip),
    .clr_mode   (clr_mode),
    .stat_rd    (stat_rd),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .irq_mask   (irq_mask),
    .status     (status),
    .irq        (irq)
  );

  assign ais_state  = def_state[DEF_AIS];
  assign rdi_state  = def_state[DEF_RDI];
  assign mism_state = def_state[DEF_MISM];
endmodule

// File: rtl/k2_defect_mon_chk.sv
module k2_defect_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic [3:0] k2_lsn,
  input logic [2:0] irq_mask,
  input logic       clr_mode,
  input logic       stat_rd,
  input logic       stat_wr,
  input logic [2:0] stat_wdata,
  input logic       ais_state,
  input logic       rdi_state,
  input logic       mism_state,
  input logic [2:0] status,
  input logic       irq
);
  // R9
  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable({ais_state, rdi_state, mism_state}));

  // R1
  a_r1_ais_on_111: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_state) |-> $past(frame_stb && (k2_lsn[2:0] == 3'b111)));

  // R3
  a_r3_rdi_on_110: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdi_state) |-> $past(frame_stb && (k2_lsn[2:0] == 3'b110)));

  // R10
  a_r10_status_follows_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mism_state, rdi_state, ais_state}) |->
      ((status & ({mism_state, rdi_state, ais_state} ^ $past({mism_state, rdi_state, ais_state})))
        == ({mism_state, rdi_state, ais_state} ^ $past({mism_state, rdi_state, ais_state}))));

  // R12
  a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && stat_rd && !frame_stb) |=> (status == 3'b000));

  // R11
  a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_mode && stat_wr && !frame_stb) |=> ((status & $past(stat_wdata)) == 3'b000));

  // R13
  a_r13_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ~irq_mask) != 3'b000));
endmodule

bind k2_defect_mon k2_defect_mon_chk u_chk (.*);

// File: tb/sim_k2_defect_mon.sv
module sim_k2_defect_mon;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_stb, pers_sel, arch_sel, dir_sel, clr_mode, stat_rd, stat_wr;
  logic [3:0] k2_lsn;
  logic [2:0] irq_mask, stat_wdata, status;
  logic       ais_state, rdi_state, mism_state, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  k2_defect_mon u0 (.*);

  // {k2 nibble, pers_sel, exp mism, exp rdi, exp ais}, one frame each, from reset
  localparam int NV = 17;
  localparam logic [7:0] VEC [NV] = '{
    8'h78, 8'h78, 8'h79, 8'h69, 8'h69, 8'h6A, 8'h5A, 8'h4A, 8'h48,
    8'h4C, 8'hDC, 8'h5C, 8'h5C, 8'h8C, 8'h0C, 8'h0C, 8'h08
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] v);
    @(negedge clk);
    k2_lsn    = v;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic wr_stat(input logic [2:0] d);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 3'b000;
  endtask

  task automatic rd_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; k2_lsn = 4'h0; pers_sel = 1'b1;
    arch_sel = 1'b0; dir_sel = 1'b0; clr_mode = 1'b0; stat_rd = 1'b0;
    stat_wr = 1'b0; irq_mask = 3'b000; stat_wdata = 3'b000;
    repeat (3) @(negedge clk);
    check("R14 states", {1'b0, mism_state, rdi_state, ais_state}, 4'h0);
    check("R14 status/irq", {status, irq}, 4'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6 R7 with 3-frame persistence
    for (int i = 0; i < NV; i++) begin
      pers_sel = VEC[i][3];
      frame(VEC[i][7:4]);
      check($sformatf("R1/R2/R3/R7 vector %0d", i),
            {1'b0, mism_state, rdi_state, ais_state}, {1'b0, VEC[i][2:0]});
    end
    check("R10 all changed", {1'b0, status}, 4'b0111);
    wr_stat(3'b111);
    check("R11 write clears", {1'b0, status}, 4'b0000);

    // R8 / R4: 5-frame persistence, interrupted run
    pers_sel = 1'b0;
    repeat (4) frame(4'h7);
    frame(4'h0);
    repeat (4) frame(4'h7);
    check("R8 interrupted run", {3'b000, ais_state}, 4'h0);
    frame(4'h7);
    check("R4 five frames", {3'b000, ais_state}, 4'h1);
    check("R10 set on declare", {1'b0, status}, 4'b0001);

    // R9: no strobe, k2 changes
    @(negedge clk); k2_lsn = 4'h0;
    repeat (10) @(negedge clk);
    check("R9 no strobe", {1'b0, mism_state, rdi_state, ais_state}, 4'b0001);

    // R13
    check("R13 irq unmasked", {3'b000, irq}, 4'h1);
    irq_mask = 3'b001; @(negedge clk);
    check("R13 irq masked", {3'b000, irq}, 4'h0);
    irq_mask = 3'b000;

    // R11 in clear-on-write mode
    rd_stat();
    check("R11 read ignored", {1'b0, status}, 4'b0001);
    wr_stat(3'b010);
    check("R11 other bit write", {1'b0, status}, 4'b0001);
    wr_stat(3'b001);
    check("R11 targeted clear", {1'b0, status}, 4'b0000);

    // R12 clear-on-read, and R2 removal at 5 frames
    clr_mode = 1'b1;
    repeat (4) frame(4'h0);
    check("R2 not yet removed", {3'b000, ais_state}, 4'h1);
    frame(4'h0);
    check("R2 removed", {3'b000, ais_state}, 4'h0);
    wr_stat(3'b111);
    check("R12 write ignored", {1'b0, status}, 4'b0001);
    rd_stat();
    check("R12 read clears", {status, irq}, 4'h0);

    // R6 unidirectional, R5 1:n
    clr_mode = 1'b0; pers_sel = 1'b1; dir_sel = 1'b1;
    repeat (3) frame(4'h5);
    check("R6 uni sees 101", {3'b000, mism_state}, 4'h1);
    repeat (3) frame(4'h4);
    check("R6 uni accepts 100", {3'b000, mism_state}, 4'h0);
    arch_sel = 1'b1;
    repeat (3) frame(4'hC);
    check("R5 1:n accepts bit3=1", {3'b000, mism_state}, 4'h0);
    repeat (2) frame(4'h4);
    frame(4'h5);
    check("R5/R6 cause swap", {3'b000, mism_state}, 4'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule